// File: doc/BRIEF.md
# Two-Wire Slave Front End with Write-Busy Polling

This block sits behind the SCL and SDA pins of a multi-channel nonvolatile register device. It oversamples both lines with the system clock and finds start and stop conditions. It then shifts in an address byte and acknowledges it only when the byte matches in full: a fixed device-type code in the upper nibble and four strapped address pins in the lower nibble. After the address it takes one instruction byte, splits it into a 4-bit opcode and a 4-bit register pointer, and presents both with a one-cycle strobe. Any data bytes that follow are acknowledged and otherwise left to the rest of the device.

When the instruction was a nonvolatile write, the stop that ends the transaction launches a timed internal write cycle. During that window the slave ignores its own address. A bus master can therefore poll: it issues a start and the address, and repeats until an acknowledge comes back. The length of the window is a clock-cycle count set by a parameter. At 50 MHz the default count gives about 5 ms.

Top module: `pbs_top`

## Requirements
- R1: After reset, `sda_oe_o`, `busy_o` and `instr_vld_o` are all 0.
- R2: An address byte (sent MSB first) whose bits [7:4] differ from the type code (default 4'b0101) is not acknowledged.
- R3: An address byte whose bits [3:0] differ from the current level of `dev_addr_i` is not acknowledged. When both nibbles match, the byte is acknowledged.
- R4: An acknowledge pulls SDA low through `sda_oe_o`. It is asserted only after the SCL falling edge that ends the eighth bit, and it is released at the next SCL falling edge, so it covers the whole ninth clock.
- R5: The byte after an acknowledged address is acknowledged and captured. `opcode_o` takes bits [7:4] and `ptr_o` takes bits [3:0], and `instr_vld_o` pulses high for exactly one clock.
- R6: After an address that is not acknowledged, the block acknowledges nothing and captures no instruction until the next start.
- R7: A stop that follows a captured instruction with the write opcode (default 4'b1100) raises `busy_o` for exactly WCYC_CYCLES clocks.
- R8: While `busy_o` is high, a matching address byte is not acknowledged.
- R9: Once `busy_o` has fallen, a matching address and the following instruction are acknowledged as normal.
- R10: A start seen in the middle of a transaction restarts address matching from the first bit, and a partial byte is discarded.
- R11: A stop after an instruction with any other opcode leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| dev_addr_i | input | 4 | Strapped address pins, compared with address bits [3:0] |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| opcode_o | output | 4 | Opcode of the last captured instruction |
| ptr_o | output | 4 | Register pointer of the last captured instruction |
| instr_vld_o | output | 1 | One-cycle strobe when an instruction is captured |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that SCL and SDA never change in the same system-clock sample. They also assume that each bus phase lasts several clocks longer than the synchroniser delay, so that every SCL edge and every start or stop is seen as a single pulse. The bench drives the bus from tasks in which every phase lasts eight clocks. SDA changes only while SCL has been low for a full phase, except at starts and stops, where it changes with SCL held high. Polls are timed to fall well inside the shortened busy window that the bench selects.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_IGNORE
  } pbs_state_e;

  function automatic logic addr_hit(input logic [7:0] b, input logic [3:0] tcode,
                                    input logic [3:0] pins);
    return (b[7:4] == tcode) && (b[3:0] == pins);
  endfunction

  function automatic logic [3:0] op_field(input logic [7:0] b);
    return b[7:4];
  endfunction

  function automatic logic [3:0] ptr_field(input logic [7:0] b);
    return b[3:0];
  endfunction
endpackage

// File: rtl/pbs_line_sync.sv
module pbs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_p,
  output logic stop_p
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] scl_q;
  logic [LEN-1:0] sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[LEN-2:0], scl_i};
      sda_q <= {sda_q[LEN-2:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now  = scl_q[LEN-2];
  assign scl_old  = scl_q[LEN-1];
  assign sda_now  = sda_q[LEN-2];
  assign sda_old  = sda_q[LEN-1];
  assign sda_lvl  = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_p  = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_p   = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/pbs_shifter.sv
module pbs_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            shift_en,
  input  logic            bit_in,
  output logic [BITS-1:0] byte_o,
  output logic            full_o
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(BITS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      byte_o <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (shift_en && !full_o) begin
      cnt    <= cnt + 1'b1;
      byte_o <= {byte_o[BITS-2:0], bit_in};
    end
  end

  assign full_o = (cnt == FULL_CNT);
endmodule

// File: rtl/pbs_wcycle_timer.sv
module pbs_wcycle_timer #(
  parameter int WCYC_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  localparam int CW = $clog2(WCYC_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WCYC_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (launch)         remain <= LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/pbs_top.sv
module pbs_top
  import pbs_pkg::*;
#(
  parameter logic [3:0] TYPE_CODE   = 4'b0101,
  parameter logic [3:0] NV_OPCODE   = 4'b1100,
  parameter int         WCYC_CYCLES = 250000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [3:0] dev_addr_i,
  output logic       sda_oe_o,
  output logic [3:0] opcode_o,
  output logic [3:0] ptr_o,
  output logic       instr_vld_o,
  output logic       busy_o
);
  logic scl_rise_w, scl_fall_w, sda_lvl_w, start_w, stop_w;
  logic [7:0] rx_byte_w;
  logic byte_full_w, shift_en_w, shift_clr_w;
  logic ack_ph, nv_pend_w, addr_ack_w, launch_w;
  logic active_w;
  pbs_state_e state;

  pbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise_w), .scl_fall(scl_fall_w), .sda_lvl(sda_lvl_w),
    .start_p(start_w), .stop_p(stop_w)
  );

  assign active_w    = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_DATA);
  assign shift_en_w  = scl_rise_w & active_w & ~ack_ph;
  assign shift_clr_w = start_w | stop_w | (scl_fall_w & ack_ph);

  pbs_shifter #(.BITS(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(shift_clr_w), .shift_en(shift_en_w),
    .bit_in(sda_lvl_w), .byte_o(rx_byte_w), .full_o(byte_full_w)
  );

  assign launch_w = stop_w & nv_pend_w;

  pbs_wcycle_timer #(.WCYC_CYCLES(WCYC_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .busy(busy_o)
  );

  logic byte_end_w;
  assign byte_end_w = scl_fall_w & ~ack_ph & byte_full_w;
  assign addr_ack_w = byte_end_w && (state == ST_ADDR) && !busy_o &&
                      addr_hit(rx_byte_w, TYPE_CODE, dev_addr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sda_oe_o    <= 1'b0;
      ack_ph      <= 1'b0;
      nv_pend_w   <= 1'b0;
      instr_vld_o <= 1'b0;
      opcode_o    <= '0;
      ptr_o       <= '0;
    end else begin
      instr_vld_o <= 1'b0;
      if (start_w) begin
        state     <= ST_ADDR;
        sda_oe_o  <= 1'b0;
        ack_ph    <= 1'b0;
        nv_pend_w <= 1'b0;
      end else if (stop_w) begin
        state     <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        ack_ph    <= 1'b0;
        nv_pend_w <= 1'b0;
      end else if (scl_fall_w && ack_ph) begin
        sda_oe_o <= 1'b0;
        ack_ph   <= 1'b0;
      end else if (byte_end_w) begin
        unique case (state)
          ST_ADDR: begin
            if (addr_ack_w) begin
              sda_oe_o <= 1'b1;
              ack_ph   <= 1'b1;
              state    <= ST_INSTR;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_INSTR: begin
            sda_oe_o    <= 1'b1;
            ack_ph      <= 1'b1;
            opcode_o    <= op_field(rx_byte_w);
            ptr_o       <= ptr_field(rx_byte_w);
            instr_vld_o <= 1'b1;
            nv_pend_w   <= (op_field(rx_byte_w) == NV_OPCODE);
            state       <= ST_DATA;
          end
          ST_DATA: begin
            sda_oe_o <= 1'b1;
            ack_ph   <= 1'b1;
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       instr_vld_o,
  input logic       start_w,
  input logic       stop_w,
  input logic       scl_fall_w,
  input logic       nv_pend_w,
  input logic       addr_ack_w,
  input logic [7:0] rx_byte_w,
  input logic [3:0] dev_addr_i
);
  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall_w)); // R4
  AST_ADDR_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_w |-> (rx_byte_w[7:4] == 4'b0101) && (rx_byte_w[3:0] == dev_addr_i)); // R3
  AST_INSTR_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_vld_o |=> !instr_vld_o); // R5
  AST_STOP_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_w && nv_pend_w) |=> busy_o); // R7
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o); // R8
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_oe_o); // R10
endmodule

bind pbs_top pbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
  .instr_vld_o(instr_vld_o), .start_w(start_w), .stop_w(stop_w),
  .scl_fall_w(scl_fall_w), .nv_pend_w(nv_pend_w), .addr_ack_w(addr_ack_w),
  .rx_byte_w(rx_byte_w), .dev_addr_i(dev_addr_i)
);

// File: tb/pbs_top_tb_top.sv
module pbs_top_tb_top;
  localparam int WCYC = 1500;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] dev_addr = 4'b0110;
  logic sda_oe, instr_vld, busy;
  logic [3:0] opcode, ptr;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  pbs_top #(.WCYC_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_addr_i(dev_addr), .sda_oe_o(sda_oe), .opcode_o(opcode), .ptr_o(ptr),
    .instr_vld_o(instr_vld), .busy_o(busy)
  );

  int n_chk = 0, n_bad = 0, n_instr = 0, run_len = 0, last_len = 0;
  logic [3:0] seen_op = '0, seen_ptr = '0;
  bit done = 0;

  always @(posedge clk) begin
    if (instr_vld) begin
      n_instr  <= n_instr + 1;
      seen_op  <= opcode;
      seen_ptr <= ptr;
    end
    if (busy) run_len <= run_len + 1;
    else if (run_len != 0) begin
      last_len <= run_len;
      run_len  <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl = 1'b1; hq(); sda_m = 1'b0; hq(); scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hq(); scl = 1'b1; hq(); scl = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hq(); scl = 1'b1; hq();
    ack = ~sda_line;
    hq(); scl = 1'b0; hq();
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(instr_vld == 1'b0, "R1 vld", instr_vld, 0);
  endtask

  task automatic t_good_instr();
    bit a;
    int n0 = n_instr;
    bus_start();
    send_bits(8'h56, 8);
    hq();
    chk(sda_oe == 1'b1, "R4 oe in ninth clock", sda_oe, 1);
    scl = 1'b1; hq(); a = ~sda_line; hq(); scl = 1'b0; hq();
    chk(a, "R3 match acked", a, 1);
    chk(sda_oe == 1'b0, "R4 released after ninth", sda_oe, 0);
    xfer(8'h3A, a);
    chk(a, "R5 instr acked", a, 1);
    chk(n_instr == n0 + 1, "R5 one strobe", n_instr - n0, 1);
    chk(seen_op == 4'h3 && seen_ptr == 4'hA, "R5 fields",
        {seen_op, seen_ptr}, 8'h3A);
    bus_stop(); hq();
    chk(busy == 1'b0, "R11 no busy", busy, 0);
  endtask

  task automatic t_type_bad();
    bit a;
    int n0 = n_instr;
    bus_start();
    xfer(8'h76, a);
    chk(!a, "R2 type mismatch", a, 0);
    xfer(8'hC1, a);
    chk(!a, "R6 ignored byte", a, 0);
    chk(n_instr == n0, "R6 no capture", n_instr - n0, 0);
    bus_stop(); hq();
    chk(busy == 1'b0, "R6 no busy", busy, 0);
  endtask

  task automatic t_pins();
    bit a;
    dev_addr = 4'b1010;
    bus_start(); xfer(8'h56, a); bus_stop();
    chk(!a, "R3 pin mismatch", a, 0);
    dev_addr = 4'b0110;
    hq();
    bus_start(); xfer(8'h56, a); bus_stop();
    chk(a, "R3 pins retracked", a, 1);
  endtask

  task automatic t_rep_start();
    bit a;
    int n0 = n_instr;
    bus_start(); xfer(8'h56, a);
    send_bits(8'hC0, 4);
    bus_start();
    xfer(8'h56, a);
    chk(a, "R10 addr after restart", a, 1);
    xfer(8'h47, a);
    chk(n_instr == n0 + 1 && seen_op == 4'h4 && seen_ptr == 4'h7, "R10 instr",
        {seen_op, seen_ptr}, 8'h47);
    bus_start(); xfer(8'h11, a);
    chk(!a, "R10 bad addr", a, 0);
    bus_start(); xfer(8'h56, a);
    chk(a, "R10 rematch", a, 1);
    bus_stop(); hq();
    chk(busy == 1'b0, "R11 no busy", busy, 0);
  endtask

  task automatic t_nv_poll();
    bit a;
    bus_start(); xfer(8'h56, a); xfer(8'hC5, a); bus_stop();
    hq();
    chk(busy == 1'b1, "R7 busy after stop", busy, 1);
    bus_start(); xfer(8'h56, a); bus_stop();
    chk(!a, "R8 poll silent", a, 0);
    while (busy) @(negedge clk);
    hq();
    chk(last_len == WCYC, "R7 busy length", last_len, WCYC);
    bus_start(); xfer(8'h56, a);
    chk(a, "R9 poll acked", a, 1);
    xfer(8'h21, a);
    chk(a && seen_op == 4'h2, "R9 instr", seen_op, 2);
    bus_stop(); hq();
    chk(busy == 1'b0, "R11 no relaunch", busy, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    hq();
    t_reset();
    t_good_instr();
    t_type_bad();
    t_pins();
    t_rep_start();
    t_nv_poll();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end
endmodule